// File: doc/BRIEF.md
# Two-Dimensional 8x8 Inverse DCT Core

This block rebuilds an 8x8 tile of pixels from its 64 frequency coefficients. It does the work as two passes of an eight-point one-dimensional inverse transform. The first pass works along each coefficient row. Its results go into a 64-word by 15-bit transpose store, written one row after another. The second pass reads that store one column at a time and produces unsigned 8-bit pixels. The cosine weights are signed 16-bit constants with 14 fractional bits. Intermediate words keep 2 fractional bits. Final values are rounded and then clamped to the pixel range.

A producer waits for `ready`. It then raises `coef_strb` together with the first coefficient and supplies the other 63 on the next 63 clocks, with no gaps. The block handles one tile at a time. The pixels of a tile come out as one unbroken run of 64 valid cycles at a fixed distance from the strobe, and the first pixel is tagged with a start flag. `ready` returns once the tile has left. An asynchronous active-low reset and a synchronous active-high clear both bring the core back to its idle state.

Top module: `idct2d_core`

## Requirements
- R1: `ready` is 1 when idle. It falls in the cycle after an accepted strobe and stays 0 up to and including the cycle that shows the 64th pixel. `pix_valid` is never 1 while `ready` is 1.
- R2: A tile is accepted when `coef_strb` and `ready` are both 1. Word n (n = 0..63), taken n cycles after the strobe cycle, is coefficient X[v][u] with v = n/8 (vertical frequency) and u = n%8 (horizontal frequency). Each word is an 11-bit two's-complement value.
- R3: The 64 pixels appear in 64 consecutive `pix_valid` cycles. Output word n is pixel p[y][x] with x = n/8 and y = n%8, so the order is column by column.
- R4: `pix_sob` is 1 only in the cycle of output word 0, and only together with `pix_valid`.
- R5: The weight for position i and frequency f is w(i,f) = round(8192·cos((2i+1)fπ/16)) for f>0 and round(8192/√2) for f=0. The first pass forms t[v][x] = floor((Σu w(x,u)·X[v][u] + 2048) / 4096), held as 15-bit signed.
- R6: The pixel is p[y][x] = floor((Σv w(y,v)·t[v][x] + 32768) / 65536), clamped to the range 0..255.
- R7: A strobe while `ready` is 0 has no effect on the tile in flight. Coefficient inputs are ignored outside the 64 loading cycles.
- R8: While `rst_n` is 0, `ready` is 1 and `pix_valid` and `pix_sob` are 0 at once, without waiting for a clock edge.
- R9: When `clr` is 1 at a clock edge, the next cycle shows `pix_valid` = 0 and `ready` = 1. No pixel of the discarded tile appears afterwards.
- R10: The transpose store holds 64 words of 15 bits. First-pass results are written in row order (address 8v+x) and read in column order.
- R11: Pixel word 0 is valid 82 cycles after the strobe cycle. `ready` rises 146 cycles after the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear, active high |
| coef_strb | input | 1 | Marks coefficient word 0 of a tile |
| coef_in | input | 11 | Signed coefficient word |
| pix_out | output | 8 | Unsigned pixel word |
| pix_sob | output | 1 | Start of output tile |
| pix_valid | output | 1 | Pixel word valid |
| ready | output | 1 | Core idle; a strobe will be accepted |

## Verification
A fault in the sequencer's count or state shows at the ports within one tile. Either `ready` rises at the wrong cycle, or the valid run starts off cycle 82 or breaks before it reaches 64 words. A wrong transpose address, or a lane with the wrong weight, leaves the timing intact but corrupts particular pixels. Single-coefficient tiles expose such a fault as a misplaced pattern in the first tile that uses the affected row or column. Rounding and clamp faults only show on tiles that drive values to a half-step or past the pixel range, so the stimulus pushes the DC term to both extremes.

// File: rtl/idct_pkg.sv
`timescale 1ns/1ps
package idct_pkg;
  localparam int NPT     = 8;
  localparam int NBLK    = NPT * NPT;
  localparam int IDX_W   = $clog2(NBLK);
  localparam int CQ_W    = 16;
  localparam int CQ_FRAC = 14;

  // half-scaled cosine magnitude for angle index k (k*pi/16), k in 0..8
  function automatic logic signed [CQ_W-1:0] cos_mag(input int k);
    case (k)
      0: return 16'sd8192;
      1: return 16'sd8035;
      2: return 16'sd7568;
      3: return 16'sd6811;
      4: return 16'sd5793;
      5: return 16'sd4551;
      6: return 16'sd3135;
      7: return 16'sd1598;
      default: return 16'sd0;
    endcase
  endfunction

  // weight for spatial position pos and frequency f
  function automatic logic signed [CQ_W-1:0] cos_q(input int pos, input logic [2:0] f);
    int k;
    if (f == 3'd0) return cos_mag(4);
    k = ((2 * pos + 1) * int'(f)) % 32;
    if (k > 16) k = 32 - k;
    if (k > 8) return -cos_mag(16 - k);
    return cos_mag(k);
  endfunction

  // round half up after arithmetic shift, then clamp
  function automatic longint sat_shift(input longint a, input int sh,
                                       input longint lo, input longint hi);
    longint r;
    r = (a + (longint'(1) <<< (sh - 1))) >>> sh;
    if (r < lo) r = lo;
    if (r > hi) r = hi;
    return r;
  endfunction
endpackage

// File: rtl/idct_seq.sv
`timescale 1ns/1ps
module idct_seq
  import idct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             strb,
  input  logic             pix_last,
  output logic             ready,
  output logic             in_take,
  output logic [IDX_W-1:0] in_idx,
  output logic             rd_go,
  output logic [IDX_W-1:0] rd_cnt
);
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_FLUSH, S_READ, S_DRAIN} seq_st_t;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBLK - 1);
  localparam logic [IDX_W-1:0] FLUSH_END = IDX_W'(NPT - 1);

  seq_st_t          st;
  logic [IDX_W-1:0] cnt;

  assign ready   = (st == S_IDLE);
  assign in_take = (st == S_IDLE && strb) || (st == S_LOAD);
  assign in_idx  = (st == S_LOAD) ? cnt : '0;
  assign rd_go   = (st == S_READ);
  assign rd_cnt  = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (clr) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (strb) begin st <= S_LOAD; cnt <= IDX_W'(1); end
        S_LOAD:
          if (cnt == LAST_IDX) begin st <= S_FLUSH; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_FLUSH:
          if (cnt == FLUSH_END) begin st <= S_READ; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_READ:
          if (cnt == LAST_IDX) begin st <= S_DRAIN; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_DRAIN: if (pix_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: ready only drops because a strobe was accepted
  p_ready_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(strb)) else $error("ready fell without strobe");

  // R2: loading runs on consecutive cycles with consecutive indices
  p_load_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_take && in_idx != LAST_IDX && !clr) |=> (in_take && in_idx == $past(in_idx) + 1'b1))
    else $error("coefficient burst broken");

  // R7: a strobe while busy does not release or restart the core
  p_busy_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && strb && !clr && !pix_last) |=> !ready) else $error("busy strobe acted");
endmodule

// File: rtl/idct_mac_lane.sv
`timescale 1ns/1ps
module idct_mac_lane
  import idct_pkg::*;
#(
  parameter int     IN_W  = 11,
  parameter int     OUT_W = 15,
  parameter int     SHIFT = 12,
  parameter int     POS   = 0,
  parameter longint LO    = -16384,
  parameter longint HI    = 16383
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   en,
  input  logic [2:0]             freq,
  input  logic signed [IN_W-1:0] din,
  output logic [OUT_W-1:0]       q
);
  localparam int ACC_W = IN_W + CQ_W + 3;

  logic signed [ACC_W-1:0] acc, base, sum;
  logic signed [CQ_W-1:0]  cq;

  always_comb begin
    cq   = cos_q(POS, freq);
    base = (freq == 3'd0) ? '0 : acc;
    sum  = base + ACC_W'(cq) * ACC_W'(din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      q   <= '0;
    end else if (clr) begin
      acc <= '0;
      q   <= '0;
    end else if (en) begin
      acc <= sum;
      if (freq == 3'(NPT - 1)) q <= OUT_W'(sat_shift(64'(sum), SHIFT, LO, HI));
    end
  end
endmodule

// File: rtl/idct_row_stage.sv
`timescale 1ns/1ps
module idct_row_stage
  import idct_pkg::*;
#(
  parameter int COEF_W = 11,
  parameter int MID_W  = 15,
  parameter int SHIFT  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     take,
  input  logic [IDX_W-1:0]         idx,
  input  logic signed [COEF_W-1:0] din,
  output logic                     wr_en,
  output logic [IDX_W-1:0]         wr_addr,
  output logic signed [MID_W-1:0]  wr_data
);
  localparam longint MID_LO = -(longint'(1) <<< (MID_W - 1));
  localparam longint MID_HI = (longint'(1) <<< (MID_W - 1)) - 1;

  logic [MID_W-1:0] hold [NPT];
  logic [2:0]       wr_row, wr_k;
  logic             busy;

  for (genvar g = 0; g < NPT; g++) begin : g_lane
    logic [MID_W-1:0] q;
    idct_mac_lane #(
      .IN_W(COEF_W), .OUT_W(MID_W), .SHIFT(SHIFT), .POS(g), .LO(MID_LO), .HI(MID_HI)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(take), .freq(idx[2:0]), .din(din), .q(q)
    );
    assign hold[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; wr_k <= '0; wr_row <= '0;
    end else if (clr) begin
      busy <= 1'b0; wr_k <= '0; wr_row <= '0;
    end else if (take && idx[2:0] == 3'(NPT - 1)) begin
      busy <= 1'b1; wr_k <= '0; wr_row <= idx[5:3];
    end else if (busy) begin
      wr_k <= wr_k + 1'b1;
      if (wr_k == 3'(NPT - 1)) busy <= 1'b0;
    end
  end

  assign wr_en   = busy;
  assign wr_addr = {wr_row, wr_k};
  assign wr_data = $signed(hold[wr_k]);

  // R10: row-major write run, one address step per cycle
  p_write_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[2:0] != 3'(NPT - 1) && !clr) |=> (wr_en && wr_addr == $past(wr_addr) + 1'b1))
    else $error("transpose write run broken");
endmodule

// File: rtl/idct_xpose_ram.sv
`timescale 1ns/1ps
module idct_xpose_ram #(
  parameter int W     = 15,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/idct_col_stage.sv
`timescale 1ns/1ps
module idct_col_stage
  import idct_pkg::*;
#(
  parameter int MID_W = 15,
  parameter int PIX_W = 8,
  parameter int SHIFT = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    rd_go,
  input  logic [IDX_W-1:0]        rd_cnt,
  output logic                    rd_en,
  output logic [IDX_W-1:0]        rd_addr,
  input  logic signed [MID_W-1:0] rdata,
  output logic [PIX_W-1:0]        pix,
  output logic                    pix_sob,
  output logic                    pix_valid,
  output logic                    pix_last
);
  localparam longint PIX_HI = (longint'(1) <<< PIX_W) - 1;

  logic             d_valid;
  logic [IDX_W-1:0] d_idx;
  logic [PIX_W-1:0] phold [NPT];
  logic [2:0]       col, out_k;
  logic             out_busy, last_flag;

  // column-major read: vertical index in the high half of the address
  assign rd_en   = rd_go;
  assign rd_addr = {rd_cnt[2:0], rd_cnt[5:3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_valid <= 1'b0; d_idx <= '0;
    end else if (clr) begin
      d_valid <= 1'b0; d_idx <= '0;
    end else begin
      d_valid <= rd_go; d_idx <= rd_cnt;
    end
  end

  for (genvar g = 0; g < NPT; g++) begin : g_lane
    logic [PIX_W-1:0] q;
    idct_mac_lane #(
      .IN_W(MID_W), .OUT_W(PIX_W), .SHIFT(SHIFT), .POS(g), .LO(0), .HI(PIX_HI)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(d_valid), .freq(d_idx[2:0]), .din(rdata), .q(q)
    );
    assign phold[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_busy <= 1'b0; out_k <= '0; col <= '0;
      pix <= '0; pix_valid <= 1'b0; pix_sob <= 1'b0; last_flag <= 1'b0;
    end else if (clr) begin
      out_busy <= 1'b0; out_k <= '0; col <= '0;
      pix <= '0; pix_valid <= 1'b0; pix_sob <= 1'b0; last_flag <= 1'b0;
    end else begin
      pix_valid <= out_busy;
      pix_sob   <= out_busy && col == 3'd0 && out_k == 3'd0;
      last_flag <= out_busy && col == 3'(NPT - 1) && out_k == 3'(NPT - 1);
      if (out_busy) pix <= phold[out_k];
      if (d_valid && d_idx[2:0] == 3'(NPT - 1)) begin
        out_busy <= 1'b1; out_k <= '0; col <= d_idx[5:3];
      end else if (out_busy) begin
        out_k <= out_k + 1'b1;
        if (out_k == 3'(NPT - 1)) out_busy <= 1'b0;
      end
    end
  end

  assign pix_last = pix_valid && last_flag;

  // R3: the valid run does not break before the last pixel
  p_valid_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_last && !clr) |=> pix_valid) else $error("valid run broken");

  // R4: first valid pixel of a run carries the start flag
  p_sob_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> pix_sob) else $error("run started without start flag");

  // R4: start flag lasts one cycle
  p_sob_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_sob && !clr) |=> !pix_sob) else $error("start flag repeated");

  // R10: column-major read steps by one row per cycle
  p_read_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_cnt[2:0] != 3'(NPT - 1) && !clr) |=> (rd_addr == $past(rd_addr) + IDX_W'(NPT)))
    else $error("transpose read order broken");
endmodule

// File: rtl/idct2d_core.sv
`timescale 1ns/1ps
module idct2d_core
  import idct_pkg::*;
#(
  parameter int COEF_W   = 11,
  parameter int MID_W    = 15,
  parameter int PIX_W    = 8,
  parameter int MID_FRAC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              coef_strb,
  input  logic [COEF_W-1:0] coef_in,
  output logic [PIX_W-1:0]  pix_out,
  output logic              pix_sob,
  output logic              pix_valid,
  output logic              ready
);
  localparam int SH_ROW = CQ_FRAC - MID_FRAC;
  localparam int SH_COL = CQ_FRAC + MID_FRAC;

  logic             in_take, rd_go, pix_last;
  logic [IDX_W-1:0] in_idx, rd_cnt;
  logic             wr_en, rd_en;
  logic [IDX_W-1:0] wr_addr, rd_addr;
  logic signed [MID_W-1:0] wr_data;
  logic [MID_W-1:0] rdata;

  idct_seq u_seq (
    .clk(clk), .rst_n(rst_n), .clr(clr), .strb(coef_strb), .pix_last(pix_last),
    .ready(ready), .in_take(in_take), .in_idx(in_idx), .rd_go(rd_go), .rd_cnt(rd_cnt)
  );

  idct_row_stage #(.COEF_W(COEF_W), .MID_W(MID_W), .SHIFT(SH_ROW)) u_row (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(in_take), .idx(in_idx),
    .din($signed(coef_in)), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  idct_xpose_ram #(.W(MID_W), .DEPTH(NBLK)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .re(rd_en), .raddr(rd_addr), .rdata(rdata)
  );

  idct_col_stage #(.MID_W(MID_W), .PIX_W(PIX_W), .SHIFT(SH_COL)) u_col (
    .clk(clk), .rst_n(rst_n), .clr(clr), .rd_go(rd_go), .rd_cnt(rd_cnt),
    .rd_en(rd_en), .rd_addr(rd_addr), .rdata($signed(rdata)),
    .pix(pix_out), .pix_sob(pix_sob), .pix_valid(pix_valid), .pix_last(pix_last)
  );

  // R9: a clear empties the output and idles the core on the next cycle
  p_clr_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!pix_valid && ready)) else $error("clear did not idle core");

  // R1: no pixel leaves while the core reports idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !pix_valid) else $error("valid while ready");
endmodule

// File: tb/idct2d_core_test.sv
`timescale 1ns/1ps
module idct2d_core_test;
  localparam real PI = 3.14159265358979;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        coef_strb = 1'b0;
  logic [10:0] coef_in = '0;
  logic [7:0]  pix_out;
  logic        pix_sob, pix_valid, ready;

  int n_chk = 0;
  int n_bad = 0;
  int cf [64];
  int ex [64];

  always #2 clk = ~clk;

  idct2d_core uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .coef_strb(coef_strb), .coef_in(coef_in),
    .pix_out(pix_out), .pix_sob(pix_sob), .pix_valid(pix_valid), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint wq(input int pos, input int f);
    real a;
    if (f == 0) a = 8192.0 / $sqrt(2.0);
    else a = 8192.0 * $cos(PI * real'((2 * pos + 1) * f) / 16.0);
    return longint'(int'(a));
  endfunction

  function automatic longint fdiv(input longint a, input longint b);
    longint q;
    q = a / b;
    if ((a % b) != 0 && a < 0) q = q - 1;
    return q;
  endfunction

  function automatic longint lim(input longint a, input longint lo, input longint hi);
    return (a < lo) ? lo : ((a > hi) ? hi : a);
  endfunction

  // reference: R5 first pass, R6 second pass, R2/R3 orderings
  task automatic build_ref();
    longint t [8][8];
    longint s;
    for (int v = 0; v < 8; v++)
      for (int x = 0; x < 8; x++) begin
        s = 0;
        for (int u = 0; u < 8; u++) s += wq(x, u) * longint'(cf[8 * v + u]);
        t[v][x] = lim(fdiv(s + 2048, 4096), -16384, 16383);
      end
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++) begin
        s = 0;
        for (int v = 0; v < 8; v++) s += wq(y, v) * t[v][x];
        ex[8 * x + y] = int'(lim(fdiv(s + 32768, 65536), 0, 255));
      end
  endtask

  // ab_kind: 0 none, 1 clear at cycle ab_k, 2 async reset at cycle ab_k
  task automatic run_block(input int xs1, input int xs2, input int ab_k, input int ab_kind);
    bit stray;
    stray = 1'b0;
    build_ref();
    @(negedge clk);
    chk(ready == 1'b1, "R1", "ready before strobe", ready, 1);
    coef_strb = 1'b1;
    coef_in   = 11'(cf[0]);
    for (int k = 1; k <= 150; k++) begin
      @(negedge clk);
      if (k == ab_k && ab_kind == 1) begin
        clr = 1'b1;
        coef_strb = 1'b0;
        @(negedge clk);
        clr = 1'b0;
        chk(pix_valid == 1'b0, "R9", "valid after clear", pix_valid, 0);
        chk(ready == 1'b1, "R9", "ready after clear", ready, 1);
        return;
      end
      if (k == ab_k && ab_kind == 2) begin
        rst_n = 1'b0;
        coef_strb = 1'b0;
        #1;
        chk(ready == 1'b1 && pix_valid == 1'b0 && pix_sob == 1'b0, "R8",
            "outputs in async reset (ready,valid)", {ready, pix_valid}, 2);
        @(negedge clk);
        rst_n = 1'b1;
        return;
      end
      if (k == 1) chk(ready == 1'b0, "R1", "ready after strobe", ready, 0);
      if (k == 146) begin
        chk(ready == 1'b1, "R11", "ready rise cycle", ready, 1);
        chk(pix_valid == 1'b0, "R3", "valid after 64th pixel", pix_valid, 0);
      end
      if (k >= 82 && k <= 145) begin
        if (k == 82) chk(pix_valid == 1'b1, "R11", "first pixel latency", pix_valid, 1);
        else chk(pix_valid == 1'b1, "R3", $sformatf("valid word %0d", k - 82), pix_valid, 1);
        chk(ready == 1'b0, "R1", "ready during output", ready, 0);
        chk(pix_sob == (k == 82), "R4", $sformatf("sob word %0d", k - 82), pix_sob, (k == 82));
        chk(int'(pix_out) == ex[k - 82], "R2 R5 R6 R10",
            $sformatf("pixel word %0d", k - 82), pix_out, ex[k - 82]);
      end else if (pix_valid) stray = 1'b1;
      coef_strb = (k == xs1 || k == xs2);
      coef_in   = (k < 64) ? 11'(cf[k]) : 11'($urandom);
    end
    coef_strb = 1'b0;
    chk(!stray, "R7", "no valid outside window", stray, 0);
  endtask

  task automatic idle_watch(input int n, input string req);
    bit seen, busy;
    seen = 1'b0;
    busy = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      coef_in = 11'($urandom);
      if (pix_valid) seen = 1'b1;
      if (!ready) busy = 1'b1;
    end
    chk(!seen, req, "no pixel from discarded tile", seen, 0);
    chk(!busy, req, "ready held while idle", busy, 0);
  endtask

  task automatic fill(input int dc, input int ac);
    for (int n = 0; n < 64; n++) cf[n] = ac;
    cf[0] = dc;
  endtask

  task automatic fill_rand();
    cf[0] = int'($urandom_range(0, 1023));
    for (int n = 1; n < 64; n++)
      if ($urandom_range(0, 7) == 0) cf[n] = int'($urandom_range(0, 2047)) - 1024;
      else cf[n] = int'($urandom_range(0, 128)) - 64;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(ready == 1'b1 && pix_valid == 1'b0 && pix_sob == 1'b0, "R8",
        "reset state (ready,valid)", {ready, pix_valid}, 2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ready == 1'b1 && pix_valid == 1'b0, "R1", "idle after reset", {ready, pix_valid}, 2);

    fill(0, 0);           run_block(0, 0, 0, 0);       // all zero
    fill(1023, 0);        run_block(0, 0, 0, 0);       // flat mid grey
    fill(-1024, 0);       run_block(0, 0, 0, 0);       // R6 clamp low
    fill(1023, 1023);     run_block(0, 0, 0, 0);       // R6 clamp high
    fill(512, 0); cf[1] = 700;  run_block(0, 0, 0, 0); // R2 horizontal orientation
    fill(512, 0); cf[8] = -700; run_block(0, 0, 0, 0); // R10 vertical orientation
    for (int b = 0; b < 6; b++) begin
      fill_rand();
      run_block((b % 2 == 0) ? 30 : 0, (b % 3 == 0) ? 100 : 0, 0, 0);  // R7 busy strobes
    end

    fill_rand(); run_block(0, 0, 40, 1); idle_watch(160, "R9");   // clear while loading
    fill_rand(); run_block(0, 0, 95, 1); idle_watch(160, "R9");   // clear while emitting
    fill_rand(); run_block(0, 0, 50, 2); idle_watch(160, "R8");   // async reset mid tile
    fill_rand(); run_block(0, 0, 0, 0);                           // recovers cleanly

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule